// File: doc/BRIEF.md
# JTAG Debug Transport Register Pair

This block connects an external debugger, through a JTAG TAP controller, to a simple on-chip debug bus. The TAP controller supplies the current instruction and the capture, shift and update strobes. The block provides two data registers, chosen by the instruction. One is a fixed 32-bit identification word that reports the bus address width and a version. The other is an access register. Each scan of the access register does two things. At capture it returns the outcome of the access started by the previous scan. At update it starts a new bus access.

The bus side runs on its own system clock. It uses a valid/ready request carrying an address, a 34-bit data word and a write flag. The response is a one-cycle valid pulse carrying read data and an error flag. A toggle handshake carries each request from the TCK domain to the system clock and carries the completion back. Only one access is in flight at a time. A scan that captures while an access is still outstanding reports busy, and the host repeats that request.

Top module: `dbg_scan_bridge`

## Requirements
- R1: With instruction 0x10 selected, a capture loads a 32-bit word whose bits 7:4 equal the address width ABITS and whose bits 3:0 equal VERSION; all other bits are zero. Data shifted in and updated with this instruction changes nothing.
- R2: With instruction 0x11 selected, the shift path is ABITS+36 bits long and is shifted LSB first. Bits 1:0 are the operation, bits 35:2 are the 34-bit data and bits ABITS+35:36 are the address. A launched access presents exactly that address and data on the bus.
- R3: Read data reaches the host one scan later. The data field captured by a scan holds the result of the most recent successful read. Writes and failed reads leave it unchanged.
- R4: At update, operation 1 starts a bus read and operation 2 starts a bus write. Operation 0 starts no bus transaction.
- R5: If the previous access has not completed by the time of a capture, the captured status is 3 (busy) and that scan's update starts no access.
- R6: Operation 3 starts a bus write only when the status captured in the same scan was 0. Otherwise no transaction starts, and the next status reads 1 unless a higher-priority status applies. Any other accepted update clears the status back to 0.
- R7: A bus error response makes the next captured status 2. Status 2 is sticky and no access starts while it is set. It is cleared only by the update of an operation-0 scan.
- R8: After reset the block captures status 0 with zero data. A completed access that succeeds yields status 0.
- R9: A bus request stays asserted, with stable address, data and write flag, until it is accepted by ready. No request is issued while the block is waiting for a response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Active-low reset of the TCK-domain logic |
| ir | input | IR_W | Current TAP instruction |
| capture_dr | input | 1 | TAP in capture state for the data register |
| shift_dr | input | 1 | TAP in shift state for the data register |
| update_dr | input | 1 | TAP in update state for the data register |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset of the system-clock logic |
| bus_req_valid | output | 1 | Bus request valid |
| bus_req_ready | input | 1 | Bus request accepted |
| bus_req_addr | output | ABITS | Bus request address |
| bus_req_wdata | output | 34 | Bus write data |
| bus_req_write | output | 1 | 1 for a write, 0 for a read |
| bus_rsp_valid | input | 1 | One-cycle response strobe |
| bus_rsp_rdata | input | 34 | Response read data |
| bus_rsp_err | input | 1 | Response error flag |

## Verification
The hardest outcome to reach is a busy capture, because an access normally finishes long before the next scan starts. The bench stretches the bus responder's latency to hundreds of system clocks. It then scans again straight away, so the capture lands while the access is still in flight. On that busy scan it issues an ignored write and a conditional write. A later read shows that memory was not touched, and the following status reads 1 for the dropped conditional write.

// File: rtl/dbg_scan_bridge.sv
module dbg_scan_bridge #(
  parameter int ABITS     = 5,
  parameter int VERSION   = 1,
  parameter int IR_W      = 5,
  parameter int INFO_CODE = 'h10,
  parameter int BUS_CODE  = 'h11
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic [IR_W-1:0]  ir,
  input  logic             capture_dr,
  input  logic             shift_dr,
  input  logic             update_dr,
  input  logic             tdi,
  output logic             tdo,
  input  logic             clk,
  input  logic             rst_n,
  output logic             bus_req_valid,
  input  logic             bus_req_ready,
  output logic [ABITS-1:0] bus_req_addr,
  output logic [33:0]      bus_req_wdata,
  output logic             bus_req_write,
  input  logic             bus_rsp_valid,
  input  logic [33:0]      bus_rsp_rdata,
  input  logic             bus_rsp_err
);
  localparam int DW  = 34;
  localparam int DRW = ABITS + 36;
  localparam logic [31:0] INFO_WORD = {24'd0, 4'(ABITS), 4'(VERSION)};

  logic [DRW-1:0]   sr;
  logic [ABITS-1:0] a_q;
  logic [DW-1:0]    d_q;
  logic             wr_q, req_t, ack_m, ack_s;
  logic             busy_cap, fail_q, nowr_q, outst_q;
  logic [1:0]       cap_st, st_now;
  logic [DW-1:0]    res_data;
  logic             res_err, rq_m, rq_s, ack_t, act_q, wait_q;

  wire sel_info = (ir == IR_W'(INFO_CODE));
  wire sel_bus  = (ir == IR_W'(BUS_CODE));
  wire pending  = req_t ^ ack_s;
  wire new_err  = outst_q & ~pending & res_err;
  wire [1:0]       op      = sr[1:0];
  wire [DW-1:0]    op_data = sr[35:2];
  wire [ABITS-1:0] op_addr = sr[DRW-1:36];

  assign tdo = sr[0];

  always_comb begin
    if (pending)               st_now = 2'd3;
    else if (fail_q | new_err) st_now = 2'd2;
    else if (nowr_q)           st_now = 2'd1;
    else                       st_now = 2'd0;
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      sr <= '0; a_q <= '0; d_q <= '0; wr_q <= 1'b0; req_t <= 1'b0;
      ack_m <= 1'b0; ack_s <= 1'b0; busy_cap <= 1'b0; fail_q <= 1'b0;
      nowr_q <= 1'b0; outst_q <= 1'b0; cap_st <= 2'd0;
    end else begin
      ack_m <= ack_t;
      ack_s <= ack_m;
      if (capture_dr) begin
        if (sel_bus) begin
          sr       <= {a_q, res_data, st_now};
          cap_st   <= st_now;
          busy_cap <= pending;
          if (!pending && outst_q) begin
            outst_q <= 1'b0;
            fail_q  <= fail_q | res_err;
          end
        end else if (sel_info) begin
          sr <= DRW'(INFO_WORD);
        end else begin
          sr <= '0;
        end
      end else if (shift_dr) begin
        sr <= {tdi, sr[DRW-1:1]};
      end else if (update_dr && sel_bus) begin
        if (op == 2'd3 && cap_st != 2'd0) begin
          nowr_q <= 1'b1;
        end else if (fail_q) begin
          if (op == 2'd0) begin
            fail_q <= 1'b0;
            nowr_q <= 1'b0;
          end
        end else if (!busy_cap) begin
          nowr_q <= 1'b0;
          if (op != 2'd0) begin
            a_q     <= op_addr;
            d_q     <= op_data;
            wr_q    <= op[1];
            req_t   <= ~req_t;
            outst_q <= 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rq_m <= 1'b0; rq_s <= 1'b0; ack_t <= 1'b0; act_q <= 1'b0;
      wait_q <= 1'b0; res_data <= '0; res_err <= 1'b0;
    end else begin
      rq_m <= req_t;
      rq_s <= rq_m;
      if (!act_q) begin
        if (rq_s != ack_t) act_q <= 1'b1;
      end else if (!wait_q) begin
        if (bus_req_ready) wait_q <= 1'b1;
      end else if (bus_rsp_valid) begin
        act_q   <= 1'b0;
        wait_q  <= 1'b0;
        ack_t   <= ~ack_t;
        res_err <= bus_rsp_err;
        if (!wr_q && !bus_rsp_err) res_data <= bus_rsp_rdata;
      end
    end
  end

  assign bus_req_valid = act_q & ~wait_q;
  assign bus_req_addr  = a_q;
  assign bus_req_wdata = d_q;
  assign bus_req_write = wr_q;

  // R1
  info_word_chk: assert property (@(posedge tck) disable iff (!trst_n)
    capture_dr && sel_info |=> sr[7:0] == INFO_WORD[7:0] && sr[31:8] == '0);
  // R5
  busy_status_chk: assert property (@(posedge tck) disable iff (!trst_n)
    capture_dr && sel_bus && pending |=> sr[1:0] == 2'd3);
  // R7
  no_launch_fail_chk: assert property (@(posedge tck) disable iff (!trst_n)
    update_dr && !capture_dr && !shift_dr && sel_bus && fail_q |=> $stable(req_t));
  // R4
  noop_quiet_chk: assert property (@(posedge tck) disable iff (!trst_n)
    update_dr && !capture_dr && !shift_dr && sel_bus && op == 2'd0 |=> $stable(req_t));
  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid && !bus_req_ready |=> bus_req_valid && $stable(bus_req_addr)
      && $stable(bus_req_wdata) && $stable(bus_req_write));
endmodule

// File: tb/dbg_scan_bridge_tb_top.sv
`timescale 1ns/1ps
module dbg_scan_bridge_tb_top;
  localparam int ABITS = 5;
  localparam int DRW   = ABITS + 36;
  localparam int ERRA  = 31;

  logic tck = 0, clk = 0, trst_n = 0, rst_n = 0;
  logic [4:0] ir = 5'h11;
  logic capture_dr = 0, shift_dr = 0, update_dr = 0, tdi = 0, tdo;
  logic bus_req_valid, bus_req_ready = 0, bus_req_write;
  logic [ABITS-1:0] bus_req_addr;
  logic [33:0] bus_req_wdata, bus_rsp_rdata = '0;
  logic bus_rsp_valid = 0, bus_rsp_err = 0;

  always #10 clk = ~clk;
  always #50 tck = ~tck;

  dbg_scan_bridge dut_i (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  // Bus responder
  logic [33:0] bmem [32];
  int bus_cnt = 0, rdy_cnt = 0, rsp_cnt = 0, lat_max = 5, rdy_max = 4;
  bit rbusy = 0;
  logic [33:0] r_data; logic r_err;
  logic [ABITS-1:0] last_addr, hold_a; logic [33:0] last_wdata, hold_d;
  logic last_wr, hold_w, was_wait = 0;

  initial for (int i = 0; i < 32; i++) bmem[i] = '0;

  always @(negedge clk) begin
    bus_rsp_valid = 0;
    if (bus_req_ready) begin
      bus_req_ready = 0;
      bus_cnt++;
      last_addr = bus_req_addr; last_wdata = bus_req_wdata; last_wr = bus_req_write;
      r_err = (bus_req_addr == ERRA);
      r_data = bmem[bus_req_addr];
      if (bus_req_write && !r_err) bmem[bus_req_addr] = bus_req_wdata;
      rsp_cnt = $urandom % lat_max;
      rbusy = 1; was_wait = 0;
    end else if (rbusy) begin
      if (rsp_cnt == 0) begin
        bus_rsp_valid = 1; bus_rsp_rdata = r_data; bus_rsp_err = r_err; rbusy = 0;
        rdy_cnt = $urandom % rdy_max;
      end else rsp_cnt--;
    end else if (bus_req_valid) begin
      if (was_wait) begin
        checks++;
        if (hold_a !== bus_req_addr || hold_d !== bus_req_wdata || hold_w !== bus_req_write) begin
          errors++;
          $display("FAIL R9 request changed while stalled: %h/%h expected %h/%h",
                   bus_req_addr, bus_req_wdata, hold_a, hold_d);
        end
      end
      hold_a = bus_req_addr; hold_d = bus_req_wdata; hold_w = bus_req_write;
      if (rdy_cnt == 0) bus_req_ready = 1; else begin rdy_cnt--; was_wait = 1; end
    end
  end

  // Reference model
  logic [33:0] mmem [32];
  logic [33:0] m_rdata = '0;
  bit m_fail = 0, m_now = 0;
  int m_cnt = 0;
  initial for (int i = 0; i < 32; i++) mmem[i] = '0;

  function automatic string st_tag(input int s);
    case (s)
      0: return "R8";
      1: return "R6";
      2: return "R7";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic scan(input logic [4:0] code, input int n,
                      input logic [DRW-1:0] din, output logic [DRW-1:0] dout);
    dout = '0;
    @(negedge tck); ir = code; capture_dr = 1;
    @(negedge tck); capture_dr = 0; shift_dr = 1;
    for (int i = 0; i < n; i++) begin
      tdi = din[i]; dout[i] = tdo;
      @(negedge tck);
    end
    shift_dr = 0; update_dr = 1;
    @(negedge tck); update_dr = 0;
  endtask

  task automatic do_scan(input logic [1:0] op, input logic [33:0] data,
                         input logic [ABITS-1:0] addr, input bit busy, input bit cnt_chk);
    logic [DRW-1:0] dout;
    int exp_st;
    logic [33:0] exp_d;
    exp_st = busy ? 3 : m_fail ? 2 : m_now ? 1 : 0;
    exp_d  = m_rdata;
    scan(5'h11, DRW, {addr, data, op}, dout);
    check(dout[1:0] == 2'(exp_st), st_tag(exp_st), "captured status", 64'(dout[1:0]), 64'(exp_st));
    if (!busy) check(dout[35:2] == exp_d, "R3", "captured data", 64'(dout[35:2]), 64'(exp_d));
    if (op == 3 && exp_st != 0) m_now = 1;
    else if (busy) ;
    else if (m_fail) begin if (op == 0) begin m_fail = 0; m_now = 0; end end
    else begin
      m_now = 0;
      if (op != 0) begin
        m_cnt++;
        if (addr == ERRA) m_fail = 1;
        else if (op == 1) m_rdata = mmem[addr];
        else mmem[addr] = data;
      end
    end
    if (cnt_chk) begin
      repeat (10) @(negedge tck);
      check(bus_cnt == m_cnt, "R4", "bus transaction count", 64'(bus_cnt), 64'(m_cnt));
      if (op[1] && bus_cnt == m_cnt && exp_st == 0 && !busy && !m_fail && addr != ERRA)
        check(last_addr == addr && last_wdata == data && last_wr, "R2", "bus write fields",
              {last_addr, last_wdata}, {addr, data});
    end
  endtask

  task automatic info_chk(input logic [31:0] wr);
    logic [DRW-1:0] dout;
    scan(5'h10, 32, DRW'(wr), dout);
    check(dout[31:0] == 32'h51, "R1", "info word", 64'(dout[31:0]), 64'h51);
  endtask

  initial begin
    #100000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    #230; trst_n = 1; rst_n = 1;
    @(negedge clk);
    check(bus_req_valid == 0, "R9", "request valid after reset", 64'(bus_req_valid), 0);
    // reset state
    do_scan(0, '0, '0, 0, 1);
    // info word, and writes to it ignored
    info_chk(32'hFFFF_FFFF);
    info_chk(32'h0);
    // write then read back
    do_scan(2, 34'h2_DEAD_BEEF, 3, 0, 1);
    do_scan(1, '0, 3, 0, 1);
    do_scan(0, '0, 0, 0, 1);
    // conditional write with status 0 executes
    do_scan(3, 34'h1_2345_6789, 4, 0, 1);
    do_scan(1, '0, 4, 0, 1);
    do_scan(0, '0, 0, 0, 1);
    // error: sticky failure
    do_scan(1, '0, 5'(ERRA), 0, 1);
    do_scan(2, 34'h3_0000_0001, 5, 0, 1);
    do_scan(3, 34'h3_0000_0002, 6, 0, 1);
    do_scan(0, '0, 0, 0, 1);
    do_scan(1, '0, 5, 0, 1);
    do_scan(3, 34'h0_0000_0777, 6, 0, 1);
    do_scan(2, 34'h0_0000_0777, 6, 0, 1);
    do_scan(0, '0, 0, 0, 1);
    // busy: slow responder
    lat_max = 400; rdy_max = 1;
    do_scan(1, '0, 3, 0, 0);
    do_scan(2, 34'h1_1111_1111, 3, 1, 0);
    #12000;
    do_scan(0, '0, 0, 0, 1);
    do_scan(1, '0, 3, 0, 0);
    do_scan(3, 34'h2_2222_2222, 9, 1, 0);
    #12000;
    lat_max = 5; rdy_max = 4;
    do_scan(2, 34'h0_5555_AAAA, 9, 0, 1);
    do_scan(1, '0, 9, 0, 1);
    do_scan(1, '0, 3, 0, 1);
    do_scan(0, '0, 0, 0, 1);
    // random traffic
    for (int k = 0; k < 120; k++) begin
      logic [1:0] op;
      logic [33:0] d;
      logic [ABITS-1:0] a;
      op = 2'($urandom);
      d  = {2'($urandom), $urandom};
      a  = ABITS'($urandom);
      do_scan(op, d, a, 0, 1);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule